// File: doc/BRIEF.md
# Pulse-and-Verify Memory Programming Sequencer

This block sits on the programmer side of an ultraviolet-erasable, one-byte-wide programmable memory. It writes a run of source bytes into that memory with the fast pulse-and-verify method. It fetches each byte from a simple request/acknowledge source port, then drives the memory's address lines, data lines, chip-enable, output-enable and program-strobe pins. It also drives two select outputs that tell external supply circuits which levels to apply. For each address it gives a fixed-width program pulse, reads the byte back, and repeats until the byte matches or the attempt limit is reached.

After the last address, the block drops the high programming voltage and returns the main supply from its programming level. It then reads the whole array twice, first at the low supply corner and then at the high corner, and compares every byte against the source. When it finishes it reports pass or fail. On a failure it also reports the failing address and the number of attempts made. Every time interval is given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset and while idle: `busy`, `pass` and `fail` are 0; `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are 1; `mem_dout_en` is 0; `vcc_sel` is 2'b00 (nominal); `vpp_sel` is 0.
- R2: `vcc_sel` encodes 2'b00 nominal, 2'b01 programming level, 2'b10 low corner and 2'b11 high corner. `vpp_sel`=1 (high programming voltage) is only present while `vcc_sel` is 2'b01. The main supply is raised before the high voltage is applied and stays raised until after the high voltage is removed.
- R3: Each program pulse holds `mem_pgm_n` low for exactly PULSE_NS converted to cycles (rounded up). During the pulse `mem_ce_n` is 0, `mem_oe_n` is 1 and `mem_dout_en` is 1.
- R4: `mem_addr`, `mem_dout`, `mem_ce_n` and `mem_oe_n` stay unchanged for at least the setup cycle count before `mem_pgm_n` falls. After `mem_pgm_n` rises, the data stays driven for at least the hold cycle count.
- R5: During a verify, `mem_pgm_n` is 1, `mem_oe_n` is 0 and the data lines are released. The read-back byte is sampled exactly the output-valid cycle count after `mem_oe_n` falls.
- R6: An address gets pulse after pulse until its verify matches. It is never pulsed more than MAX_TRIES times, and a match on the last allowed attempt still counts as success.
- R7: If the verify still mismatches after MAX_TRIES pulses, the block finishes with `fail`=1, `fail_addr` set to that address and `fail_tries`=MAX_TRIES. No later address is pulsed.
- R8: Addresses are handled in ascending order from 0 to WORDS-1. Each byte is fetched by holding `src_req` with `src_addr` equal to the current address until `src_ack`.
- R9: After the last address, the block reads every address once at `vcc_sel`=2'b10 and then once at 2'b11, with `vpp_sel`=0. If every byte matches the source, the block ends with `pass`=1.
- R10: If any byte mismatches in the final compare, the block ends with `fail`=1, `fail_addr` set to that address and `fail_tries`=0. No further addresses or corners are read.
- R11: `pass` and `fail` are never both 1 and are never 1 while `busy`. Both hold their value until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle) |
| src_req | output | 1 | Source byte request, held until acknowledged |
| src_addr | output | ADDR_W | Address of the requested source byte |
| src_ack | input | 1 | Source acknowledge, one cycle, with data |
| src_data | input | DATA_W | Source byte, valid with `src_ack` |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_pgm_n | output | 1 | Memory program strobe, active low |
| vcc_sel | output | 2 | Main supply level select (see R2) |
| vpp_sel | output | 1 | High programming voltage select |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| fail_addr | output | ADDR_W | Address of the failure |
| fail_tries | output | $clog2(MAX_TRIES+1) | Pulses given at the failing address, 0 for a compare failure |

## Verification
The bench builds the block with a 125 MHz clock, six words and a 3-bit address. The times are shortened to 800 ns for a pulse, 80 ns for setup and hold, and 40 ns for output-valid, which gives 100, 10, 10 and 5 cycles. With these values, full runs take a few thousand cycles, so the bench can reach a byte that needs exactly ten pulses, a byte that never programs, and weak bytes that fail only at the low corner or only at the high corner. MAX_TRIES keeps its default of 10, so the retry boundary is the one of the real method. The memory model drives wrong data until the output-valid delay has elapsed, so a read taken too early shows up as a mismatch.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC_UP,
        ST_VPP_UP,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY,
        ST_VPP_DOWN,
        ST_SETTLE,
        ST_CMP_FETCH,
        ST_CMP_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        VCC_NOMINAL = 2'b00,
        VCC_PROGRAM = 2'b01,
        VCC_LOW     = 2'b10,
        VCC_HIGH    = 2'b11
    } vcc_level_e;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (count != {CNT_W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/eprom_seq_cursor.sv
module eprom_seq_cursor #(
    parameter int ADDR_W = 13,
    parameter int WORDS  = 8192,
    parameter int TRY_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_clr,
    input  logic              addr_inc,
    input  logic              try_clr,
    input  logic              try_inc,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic [TRY_W-1:0]  tries
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst || addr_clr) begin
            addr <= '0;
        end else if (addr_inc) begin
            addr <= addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || try_clr) begin
            tries <= '0;
        end else if (try_inc) begin
            tries <= tries + 1'b1;
        end
    end

    assign addr_last = (addr == LAST);
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int WORDS       = 8192,
    parameter int MAX_TRIES   = 10,
    parameter int CLK_MHZ     = 125,
    parameter int PULSE_NS    = 100000,
    parameter int SETUP_NS    = 2000,
    parameter int HOLD_NS     = 2000,
    parameter int OE_VALID_NS = 150
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    output logic                           src_req,
    output logic [ADDR_W-1:0]              src_addr,
    input  logic                           src_ack,
    input  logic [DATA_W-1:0]              src_data,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]              mem_dout,
    output logic                           mem_dout_en,
    input  logic [DATA_W-1:0]              mem_din,
    output logic                           mem_ce_n,
    output logic                           mem_oe_n,
    output logic                           mem_pgm_n,
    output logic [1:0]                     vcc_sel,
    output logic                           vpp_sel,
    output logic                           busy,
    output logic                           pass,
    output logic                           fail,
    output logic [ADDR_W-1:0]              fail_addr,
    output logic [$clog2(MAX_TRIES+1)-1:0] fail_tries
);
    import eprom_seq_pkg::*;

    localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_MHZ);
    localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_MHZ);
    localparam int HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_MHZ);
    localparam int OEV_CYC   = ns_to_cycles(OE_VALID_NS, CLK_MHZ);
    localparam int MAX_CYC   = max_of4(PULSE_CYC, SETUP_CYC, HOLD_CYC, OEV_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int TRY_W     = $clog2(MAX_TRIES + 1);

    seq_state_e          st, st_nx;
    logic [CNT_W-1:0]    t_cnt;
    logic                t_clr, t_done;
    int                  t_lim;
    logic                addr_clr, addr_inc, try_clr, try_inc;
    logic [ADDR_W-1:0]   addr;
    logic                addr_last;
    logic [TRY_W-1:0]    tries;
    logic [DATA_W-1:0]   src_byte;
    logic                corner_hi, prog_failed, match;
    logic                pass_q, fail_q;
    logic [ADDR_W-1:0]   fail_addr_q;
    logic [TRY_W-1:0]    fail_tries_q;

    eprom_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clr(t_clr), .count(t_cnt)
    );

    eprom_seq_cursor #(.ADDR_W(ADDR_W), .WORDS(WORDS), .TRY_W(TRY_W)) u_cursor (
        .clk(clk), .rst(rst),
        .addr_clr(addr_clr), .addr_inc(addr_inc),
        .try_clr(try_clr), .try_inc(try_inc),
        .addr(addr), .addr_last(addr_last), .tries(tries)
    );

    // Dwell time of each timed state.
    always_comb begin
        case (st)
            ST_PULSE:              t_lim = PULSE_CYC;
            ST_HOLD:               t_lim = HOLD_CYC;
            ST_VERIFY, ST_CMP_READ: t_lim = OEV_CYC;
            default:               t_lim = SETUP_CYC;
        endcase
    end

    assign t_done = (int'(t_cnt) == t_lim - 1);
    assign t_clr  = (st_nx != st);
    assign match  = (mem_din == src_byte);

    always_comb begin
        st_nx    = st;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        case (st)
            ST_IDLE:      if (start) begin st_nx = ST_VCC_UP; addr_clr = 1'b1; end
            ST_VCC_UP:    if (t_done) st_nx = ST_VPP_UP;
            ST_VPP_UP:    if (t_done) st_nx = ST_FETCH;
            ST_FETCH:     if (src_ack) begin st_nx = ST_SETUP; try_clr = 1'b1; end
            ST_SETUP:     if (t_done) st_nx = ST_PULSE;
            ST_PULSE:     if (t_done) begin st_nx = ST_HOLD; try_inc = 1'b1; end
            ST_HOLD:      if (t_done) st_nx = ST_VERIFY;
            ST_VERIFY: begin
                if (t_done) begin
                    if (match) begin
                        if (addr_last) st_nx = ST_VPP_DOWN;
                        else begin st_nx = ST_FETCH; addr_inc = 1'b1; end
                    end else if (tries == TRY_W'(MAX_TRIES)) begin
                        st_nx = ST_VPP_DOWN;
                    end else begin
                        st_nx = ST_SETUP;
                    end
                end
            end
            ST_VPP_DOWN: begin
                if (t_done) begin
                    if (prog_failed) st_nx = ST_IDLE;
                    else begin st_nx = ST_SETTLE; addr_clr = 1'b1; end
                end
            end
            ST_SETTLE:    if (t_done) st_nx = ST_CMP_FETCH;
            ST_CMP_FETCH: if (src_ack) st_nx = ST_CMP_READ;
            ST_CMP_READ: begin
                if (t_done) begin
                    if (!match) st_nx = ST_IDLE;
                    else if (!addr_last) begin st_nx = ST_CMP_FETCH; addr_inc = 1'b1; end
                    else if (!corner_hi) begin st_nx = ST_SETTLE; addr_clr = 1'b1; end
                    else st_nx = ST_IDLE;
                end
            end
            default:      st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            src_byte     <= '0;
            corner_hi    <= 1'b0;
            prog_failed  <= 1'b0;
            pass_q       <= 1'b0;
            fail_q       <= 1'b0;
            fail_addr_q  <= '0;
            fail_tries_q <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && start) begin
                pass_q       <= 1'b0;
                fail_q       <= 1'b0;
                prog_failed  <= 1'b0;
                corner_hi    <= 1'b0;
                fail_addr_q  <= '0;
                fail_tries_q <= '0;
            end
            if ((st == ST_FETCH || st == ST_CMP_FETCH) && src_ack) begin
                src_byte <= src_data;
            end
            if (st == ST_VERIFY && t_done && !match && tries == TRY_W'(MAX_TRIES)) begin
                prog_failed  <= 1'b1;
                fail_addr_q  <= addr;
                fail_tries_q <= tries;
            end
            if (st == ST_VPP_DOWN && t_done && prog_failed) begin
                fail_q <= 1'b1;
            end
            if (st == ST_CMP_READ && t_done) begin
                if (!match) begin
                    fail_q       <= 1'b1;
                    fail_addr_q  <= addr;
                    fail_tries_q <= '0;
                end else if (addr_last) begin
                    if (corner_hi) pass_q <= 1'b1;
                    else corner_hi <= 1'b1;
                end
            end
        end
    end

    // Pin and supply decode from the state.
    always_comb begin
        vcc_level_e lvl;
        case (st)
            ST_IDLE:                               lvl = VCC_NOMINAL;
            ST_SETTLE, ST_CMP_FETCH, ST_CMP_READ:  lvl = corner_hi ? VCC_HIGH : VCC_LOW;
            default:                               lvl = VCC_PROGRAM;
        endcase
        vcc_sel = lvl;
    end

    assign vpp_sel     = (st == ST_VPP_UP) || (st == ST_FETCH) || (st == ST_SETUP) ||
                         (st == ST_PULSE)  || (st == ST_HOLD)  || (st == ST_VERIFY);
    assign mem_dout_en = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);
    assign mem_ce_n    = !(mem_dout_en || st == ST_VERIFY || st == ST_CMP_READ);
    assign mem_oe_n    = !(st == ST_VERIFY || st == ST_CMP_READ);
    assign mem_pgm_n   = (st != ST_PULSE);
    assign mem_addr    = addr;
    assign mem_dout    = src_byte;
    assign src_req     = (st == ST_FETCH) || (st == ST_CMP_FETCH);
    assign src_addr    = addr;
    assign busy        = (st != ST_IDLE);
    assign pass        = pass_q;
    assign fail        = fail_q;
    assign fail_addr   = fail_addr_q;
    assign fail_tries  = fail_tries_q;
endmodule

// File: rtl/eprom_seq_chk.sv
module eprom_seq_chk #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int MAX_TRIES = 10,
    parameter int CLK_MHZ   = 125,
    parameter int SETUP_NS  = 2000,
    parameter int HOLD_NS   = 2000
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           busy,
    input logic                           pass,
    input logic                           fail,
    input logic [$clog2(MAX_TRIES+1)-1:0] fail_tries,
    input logic                           mem_ce_n,
    input logic                           mem_oe_n,
    input logic                           mem_pgm_n,
    input logic                           mem_dout_en,
    input logic [ADDR_W-1:0]              mem_addr,
    input logic [DATA_W-1:0]              mem_dout,
    input logic [1:0]                     vcc_sel,
    input logic                           vpp_sel
);
    import eprom_seq_pkg::*;

    localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_MHZ);
    localparam int HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_MHZ);
    localparam int SIG_W     = ADDR_W + DATA_W + 2;

    logic [SIG_W-1:0] sig, sig_prev;
    int               stable_cnt, since_rise;

    assign sig = {mem_addr, mem_dout, mem_ce_n, mem_oe_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_prev   <= sig;
            stable_cnt <= 0;
            since_rise <= 0;
        end else begin
            sig_prev   <= sig;
            stable_cnt <= (sig != sig_prev) ? 1 : ((stable_cnt < 1000000) ? stable_cnt + 1 : stable_cnt);
            since_rise <= !mem_pgm_n ? 0 : ((since_rise < 1000000) ? since_rise + 1 : since_rise);
        end
    end

    p_vpp_needs_prog_r2: assert property (@(posedge clk) disable iff (rst)
        vpp_sel |-> (vcc_sel == 2'b01));

    p_pulse_shape_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));

    p_setup_before_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_pgm_n) |-> (stable_cnt >= SETUP_CYC));

    p_hold_after_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dout_en) |-> (since_rise >= HOLD_CYC));

    p_verify_release_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_dout_en && mem_pgm_n));

    p_tries_bound_r7: assert property (@(posedge clk) disable iff (rst)
        fail |-> (int'(fail_tries) <= MAX_TRIES));

    p_verdict_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    p_verdict_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (pass || fail) |-> !busy);
endmodule

bind eprom_burn_seq eprom_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_TRIES(MAX_TRIES),
    .CLK_MHZ(CLK_MHZ), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .pass(pass), .fail(fail),
    .fail_tries(fail_tries), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .mem_dout_en(mem_dout_en), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel)
);

// File: tb/eprom_burn_seq_tb.sv
module eprom_burn_seq_tb;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int WORDS  = 6;
    localparam int TRIES  = 10;
    localparam int PULSE  = 100;   // 800 ns at 125 MHz
    localparam int SETUP  = 10;    // 80 ns
    localparam int HOLD   = 10;    // 80 ns
    localparam int OEV    = 5;     // 40 ns

    logic clk = 0, rst = 1, start = 0;
    logic src_req, src_ack;
    logic [ADDR_W-1:0] src_addr, mem_addr, fail_addr;
    logic [DATA_W-1:0] src_data, mem_dout, mem_din;
    logic mem_dout_en, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_sel, busy, pass, fail;
    logic [1:0] vcc_sel;
    logic [3:0] fail_tries;

    always #4 clk = ~clk;

    eprom_burn_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .MAX_TRIES(TRIES),
        .CLK_MHZ(125), .PULSE_NS(800), .SETUP_NS(80), .HOLD_NS(80), .OE_VALID_NS(40)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack), .src_data(src_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .vcc_sel(vcc_sel), .vpp_sel(vpp_sel), .busy(busy), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_tries(fail_tries)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- stimulus tables (driven from initial only) -------------
    logic [DATA_W-1:0] src_mem [0:7];
    int                need    [0:7];
    bit                weak_on = 0;
    int                weak_addr = 0;
    logic [1:0]        weak_lvl = 2'b00;
    logic              model_clr = 0;

    // ---------------- memory and source model --------------------------------
    logic [DATA_W-1:0] arr    [0:7];
    int                pulses [0:7];
    int  olc, lat, lw, stab, sr, fetch_cnt, low_reads, high_reads;
    int  bad_setup, bad_hold, bad_width, bad_shape, bad_supply, bad_order;
    logic [ADDR_W+DATA_W+1:0] sig_prev;
    logic oe_prev, en_prev, pgm_prev;
    logic [DATA_W-1:0] rd;

    always_comb begin
        rd = arr[mem_addr];
        if (weak_on && vcc_sel == weak_lvl && int'(mem_addr) == weak_addr) rd = rd ^ 8'h01;
    end
    assign mem_din = (olc >= OEV - 1) ? rd : ~rd;

    always @(posedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < 8; i++) begin arr[i] <= 8'hFF; pulses[i] <= 0; end
            olc <= 0; lat <= 0; lw <= 0; stab <= 0; sr <= 0; fetch_cnt <= 0;
            low_reads <= 0; high_reads <= 0;
            bad_setup <= 0; bad_hold <= 0; bad_width <= 0; bad_shape <= 0;
            bad_supply <= 0; bad_order <= 0;
            src_ack <= 0; src_data <= '0;
            sig_prev <= '0; oe_prev <= 1; en_prev <= 0; pgm_prev <= 1;
        end else begin
            // source port: answer two cycles into a request
            if (src_ack) src_ack <= 0;
            else if (src_req) begin
                if (lat == 1) begin
                    src_ack  <= 1;
                    src_data <= src_mem[src_addr];
                    lat      <= 0;
                    if (int'(src_addr) != fetch_cnt % WORDS) bad_order <= bad_order + 1;
                    fetch_cnt <= fetch_cnt + 1;
                end else lat <= lat + 1;
            end
            // output valid delay
            olc <= (!mem_ce_n && !mem_oe_n) ? olc + 1 : 0;
            // corner reads
            if (!mem_ce_n && !mem_oe_n && oe_prev && !vpp_sel) begin
                if (vcc_sel == 2'b10) low_reads <= low_reads + 1;
                if (vcc_sel == 2'b11) high_reads <= high_reads + 1;
            end
            if (!mem_oe_n && (mem_dout_en || !mem_pgm_n)) bad_shape <= bad_shape + 1;
            // setup window before pulse
            stab <= ({mem_addr, mem_dout, mem_ce_n, mem_oe_n} != sig_prev) ? 1 : stab + 1;
            if (!mem_pgm_n && pgm_prev && stab < SETUP) bad_setup <= bad_setup + 1;
            // hold window after pulse
            sr <= !mem_pgm_n ? 0 : sr + 1;
            if (!mem_dout_en && en_prev && sr < HOLD) bad_hold <= bad_hold + 1;
            // supply ordering
            if (vpp_sel && vcc_sel != 2'b01) bad_supply <= bad_supply + 1;
            // pulse width and programming effect
            if (!mem_pgm_n) lw <= lw + 1;
            else if (lw != 0) begin
                lw <= 0;
                if (lw != PULSE) bad_width <= bad_width + 1;
                if (!mem_ce_n && mem_oe_n && mem_dout_en && vpp_sel) begin
                    pulses[mem_addr] <= pulses[mem_addr] + 1;
                    if (pulses[mem_addr] + 1 >= need[mem_addr])
                        arr[mem_addr] <= arr[mem_addr] & mem_dout;
                end else bad_shape <= bad_shape + 1;
            end
            sig_prev <= {mem_addr, mem_dout, mem_ce_n, mem_oe_n};
            oe_prev  <= mem_oe_n;
            en_prev  <= mem_dout_en;
            pgm_prev <= mem_pgm_n;
        end
    end

    // ---------------- scoreboard ---------------------------------------------
    typedef struct {
        bit exp_pass;
        bit exp_fail;
        int exp_addr;
        int exp_tries;
    } verdict_t;
    verdict_t sbq[$];
    logic busy_prev = 0;

    always @(negedge clk) begin
        if (busy_prev && !busy) begin
            if (sbq.size() == 0) begin
                chk(0, "R11", "unexpected end of run", 1, 0);
            end else begin
                verdict_t v;
                v = sbq.pop_front();
                chk(pass == v.exp_pass, "R9", "pass flag", pass, v.exp_pass);
                chk(fail == v.exp_fail, "R7", "fail flag", fail, v.exp_fail);
                if (v.exp_fail) begin
                    chk(int'(fail_addr) == v.exp_addr, "R10", "fail_addr", fail_addr, v.exp_addr);
                    chk(int'(fail_tries) == v.exp_tries, "R7", "fail_tries", fail_tries, v.exp_tries);
                end
            end
        end
        busy_prev = busy;
    end

    task automatic run_case(input bit p, input bit f, input int fa, input int ft);
        verdict_t v;
        @(negedge clk); model_clr = 1;
        @(negedge clk); model_clr = 0;
        v.exp_pass = p; v.exp_fail = f; v.exp_addr = fa; v.exp_tries = ft;
        sbq.push_back(v);
        start = 1;
        @(negedge clk); start = 0;
        chk(busy && !pass && !fail, "R11", "flags cleared on start", {busy, pass, fail}, 3'b100);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(pass == p && fail == f, "R11", "verdict held", {pass, fail}, {p, f});
        chk(bad_supply == 0, "R2", "supply order violations", bad_supply, 0);
        chk(bad_width == 0, "R3", "pulse width errors", bad_width, 0);
        chk(bad_setup == 0 && bad_hold == 0, "R4", "setup/hold errors", bad_setup + bad_hold, 0);
        chk(bad_shape == 0, "R5", "pin shape errors", bad_shape, 0);
        chk(bad_order == 0, "R8", "fetch order errors", bad_order, 0);
    endtask

    task automatic check_pulses(input int fa);
        for (int a = 0; a < WORDS; a++) begin
            int e;
            e = (a < fa) ? need[a] : ((a == fa) ? TRIES : 0);
            chk(pulses[a] == e, "R6", $sformatf("pulses at %0d", a), pulses[a], e);
        end
    endtask

    task automatic setup_case(input int seed);
        for (int a = 0; a < 8; a++) begin
            src_mem[a] = DATA_W'(seed * 37 + a * 53 + 5);
            need[a] = 1;
        end
        weak_on = 0;
    endtask

    // ---------------- watchdog -----------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ------------------------------------------
    initial begin
        setup_case(0);
        model_clr = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        model_clr = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !pass && !fail, "R1", "idle flags", {busy, pass, fail}, 0);
        chk(mem_ce_n && mem_oe_n && mem_pgm_n && !mem_dout_en, "R1", "idle pins",
            {mem_ce_n, mem_oe_n, mem_pgm_n, mem_dout_en}, 4'b1110);
        chk(vcc_sel == 2'b00 && !vpp_sel, "R1", "idle supplies", {vcc_sel, vpp_sel}, 0);

        // Case A: every byte takes one pulse -> pass, array equals source (R9)
        setup_case(1);
        run_case(1, 0, 0, 0);
        check_pulses(WORDS);
        for (int a = 0; a < WORDS; a++)
            chk(arr[a] == src_mem[a], "R9", $sformatf("content at %0d", a), arr[a], src_mem[a]);
        chk(low_reads == WORDS && high_reads == WORDS, "R9", "corner reads",
            low_reads * 100 + high_reads, WORDS * 101);
        chk(fetch_cnt == 3 * WORDS, "R8", "fetch count", fetch_cnt, 3 * WORDS);
        chk(vcc_sel == 2'b00 && !vpp_sel && mem_ce_n, "R1", "idle after run",
            {vcc_sel, vpp_sel, mem_ce_n}, 1);

        // Case B: stubborn bytes need several pulses (R6)
        setup_case(2);
        need[1] = 3; need[4] = 2;
        run_case(1, 0, 0, 0);
        check_pulses(WORDS);

        // Case C: last byte needs exactly the limit (R6 boundary)
        setup_case(3);
        need[WORDS-1] = TRIES;
        run_case(1, 0, 0, 0);
        check_pulses(WORDS);

        // Case D: byte 2 never programs (R7)
        setup_case(4);
        need[2] = TRIES + 1;
        run_case(0, 1, 2, TRIES);
        check_pulses(2);
        chk(low_reads == 0 && high_reads == 0, "R7", "no compare after failure",
            low_reads + high_reads, 0);

        // Case E: byte 3 weak at low corner (R10)
        setup_case(5);
        weak_on = 1; weak_addr = 3; weak_lvl = 2'b10;
        run_case(0, 1, 3, 0);
        chk(low_reads == 4 && high_reads == 0, "R10", "reads stop at mismatch",
            low_reads * 100 + high_reads, 400);

        // Case F: byte 5 weak at high corner (R9, R10)
        setup_case(6);
        weak_on = 1; weak_addr = 5; weak_lvl = 2'b11;
        run_case(0, 1, 5, 0);
        chk(low_reads == WORDS && high_reads == WORDS, "R10", "high corner reached",
            low_reads * 100 + high_reads, WORDS * 101);

        chk(sbq.size() == 0, "R11", "scoreboard drained", sbq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule